// File: doc/BRIEF.md
# Memory-Mapped Machine Timer

This block is the core-local timer for a small multi-hart processor cluster. It holds one free-running 64-bit tick counter shared by all harts. Each hart has its own 64-bit deadline register and one software-interrupt flag. Software reaches every register through 32-bit word reads and writes in a 64 KiB window. Each 64-bit register appears as two adjacent words, the low word at the lower address.

Every hart has a level-sensitive timer interrupt. It is high for as long as the shared counter is at or beyond that hart's deadline. It drops only when software writes a later deadline, or when the counter is written or wraps. Each hart also has a software-interrupt output that follows its flag.

The bus side is handled by a two-state machine. ST_IDLE moves to ST_RESP when a read is accepted. ST_RESP stays in ST_RESP when another read arrives and returns to ST_IDLE otherwise. Writes are taken in either state and never produce a response.

Top module: `mtimer_top`

## Requirements
- R1: The tick counter is 0 after reset. It rises by exactly one on every clock cycle that has no counter write, and wraps from all ones to zero.
- R2: The counter's low word is at window base + 0xBFF8 and its high word at base + 0xBFFC. Writing either word replaces only that half; the cycle after the write holds the written value, and counting resumes from it, carrying from the low word into the high word.
- R3: Hart h's deadline register has its low word at base + 0x4000 + 8*h and its high word 4 bytes above. It resets to all ones and reads back what was written.
- R4: timer_irq[h] is high exactly while counter >= deadline[h], compared as unsigned 64-bit values. Writing a deadline above the counter clears it in the cycle after the write.
- R5: A write to one hart's deadline changes only that hart's timer_irq.
- R6: Hart h's software flag is bit 0 of the word at base + 4*h. A write loads bit 0 and ignores the other bits. A read returns the flag in bit 0 with zeros above, and soft_irq[h] equals the flag.
- R7: Addresses outside the window (upper 16 address bits not equal to those of the base), and offsets inside it that hold no register, read as zero and ignore writes.
- R8: A read request gives rsp_valid high on the following cycle, with the register value as it stood in the request cycle. A write request never raises rsp_valid.
- R9: During and right after reset, timer_irq, soft_irq and rsp_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| timer_irq | output | NHART | Per-hart timer interrupt level |
| soft_irq | output | NHART | Per-hart software interrupt level |

## Verification
The assertions take it for granted that the counter is changed only by a write to its own address, or by the wrap from all ones. An interrupt fall that has neither cause is therefore treated as an error. They also assume that a request is one cycle long and that only a read may be answered. The stimulus drives every request for exactly one cycle, at word-aligned addresses. It sweeps all four harts and lets the counter wrap only in the dedicated wrap sequence.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    // Bus-side access state
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    // Kind of register an address selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SOFT = 2'd1,
        SEL_CMP  = 2'd2,
        SEL_TIME = 2'd3
    } sel_kind_e;

    localparam int          BUS_W        = 32;
    localparam int          CNT_W        = 2 * BUS_W;
    localparam logic [31:0] DEF_BASE     = 32'h0200_0000;
    localparam int          DEF_SOFT_OFF = 32'h0000;
    localparam int          DEF_CMP_OFF  = 32'h4000;
    localparam int          DEF_TIME_OFF = 32'hBFF8;

endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode
    import mtimer_pkg::*;
#(
    parameter int          NHART    = 4,
    parameter logic [31:0] BASE     = DEF_BASE,
    parameter int          SOFT_OFF = DEF_SOFT_OFF,
    parameter int          CMP_OFF  = DEF_CMP_OFF,
    parameter int          TIME_OFF = DEF_TIME_OFF,
    parameter int          HART_W   = 2
) (
    input  logic [31:0]       addr,
    output sel_kind_e         kind,
    output logic [HART_W-1:0] hart,
    output logic              hi_word
);

    localparam logic [16:0] SOFT_LO = 17'(SOFT_OFF);
    localparam logic [16:0] SOFT_HI = 17'(SOFT_OFF + 4 * NHART);
    localparam logic [16:0] CMP_LO  = 17'(CMP_OFF);
    localparam logic [16:0] CMP_HI  = 17'(CMP_OFF + 8 * NHART);
    localparam logic [15:0] TIME_V  = 16'(TIME_OFF);

    logic        in_region;
    logic [16:0] off;
    logic [16:0] soft_diff;
    logic [16:0] cmp_diff;
    logic        hit_soft;
    logic        hit_cmp;
    logic        hit_time;

    assign in_region = (addr[31:16] == BASE[31:16]);
    assign off       = {1'b0, addr[15:0]};
    assign soft_diff = off - SOFT_LO;
    assign cmp_diff  = off - CMP_LO;

    assign hit_soft = in_region && (off >= SOFT_LO) && (off < SOFT_HI);
    assign hit_cmp  = in_region && (off >= CMP_LO) && (off < CMP_HI);
    assign hit_time = in_region && (off[15:3] == TIME_V[15:3]);

    always_comb begin
        kind    = SEL_NONE;
        hart    = '0;
        hi_word = 1'b0;
        if (hit_soft) begin
            kind = SEL_SOFT;
            hart = HART_W'(soft_diff >> 2);
        end else if (hit_cmp) begin
            kind    = SEL_CMP;
            hart    = HART_W'(cmp_diff >> 3);
            hi_word = cmp_diff[2];
        end else if (hit_time) begin
            kind    = SEL_TIME;
            hi_word = off[2];
        end
    end

endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter
    import mtimer_pkg::*;
#(
    parameter int HALF_W = BUS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] value
);

    logic [2*HALF_W-1:0] count_q;
    logic [2*HALF_W-1:0] count_d;

    always_comb begin
        if (wr_lo) begin
            count_d = {count_q[2*HALF_W-1:HALF_W], wdata};
        end else if (wr_hi) begin
            count_d = {wdata, count_q[HALF_W-1:0]};
        end else begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign value = count_q;

endmodule

// File: rtl/mtimer_cmp_slot.sv
module mtimer_cmp_slot
    import mtimer_pkg::*;
#(
    parameter int HALF_W = BUS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    input  logic [2*HALF_W-1:0] now,
    output logic [2*HALF_W-1:0] deadline,
    output logic                irq
);

    logic [2*HALF_W-1:0] dl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dl_q <= '1;
        end else if (wr_lo) begin
            dl_q[HALF_W-1:0] <= wdata;
        end else if (wr_hi) begin
            dl_q[2*HALF_W-1:HALF_W] <= wdata;
        end
    end

    assign deadline = dl_q;
    assign irq      = (now >= dl_q);

endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
    import mtimer_pkg::*;
#(
    parameter int          NHART    = 4,
    parameter logic [31:0] BASE     = DEF_BASE,
    parameter int          SOFT_OFF = DEF_SOFT_OFF,
    parameter int          CMP_OFF  = DEF_CMP_OFF,
    parameter int          TIME_OFF = DEF_TIME_OFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [31:0]      req_addr,
    input  logic [31:0]      req_wdata,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    output logic [NHART-1:0] timer_irq,
    output logic [NHART-1:0] soft_irq
);

    localparam int HART_W = (NHART > 1) ? $clog2(NHART) : 1;

    sel_kind_e                    dec_kind;
    logic [HART_W-1:0]            dec_hart;
    logic                         dec_hi;
    logic                         wr_en;
    logic                         rd_en;
    logic [CNT_W-1:0]             time_q;
    logic [NHART-1:0][CNT_W-1:0]  cmp_all;
    logic [NHART-1:0]             cmp_wr_lo;
    logic [NHART-1:0]             cmp_wr_hi;
    logic [NHART-1:0]             soft_q;
    logic                         time_wr_lo;
    logic                         time_wr_hi;
    logic [BUS_W-1:0]             rd_word;
    logic [BUS_W-1:0]             rdata_q;
    bus_state_e                   state_q;
    bus_state_e                   state_d;

    assign wr_en = req_valid && req_write;
    assign rd_en = req_valid && !req_write;

    mtimer_decode #(
        .NHART    (NHART),
        .BASE     (BASE),
        .SOFT_OFF (SOFT_OFF),
        .CMP_OFF  (CMP_OFF),
        .TIME_OFF (TIME_OFF),
        .HART_W   (HART_W)
    ) u_decode (
        .addr    (req_addr),
        .kind    (dec_kind),
        .hart    (dec_hart),
        .hi_word (dec_hi)
    );

    assign time_wr_lo = wr_en && (dec_kind == SEL_TIME) && !dec_hi;
    assign time_wr_hi = wr_en && (dec_kind == SEL_TIME) && dec_hi;

    mtimer_counter #(
        .HALF_W (BUS_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (time_wr_lo),
        .wr_hi (time_wr_hi),
        .wdata (req_wdata),
        .value (time_q)
    );

    for (genvar h = 0; h < NHART; h++) begin : gen_slot
        logic sel_h;
        assign sel_h        = wr_en && (dec_kind == SEL_CMP) && (dec_hart == HART_W'(h));
        assign cmp_wr_lo[h] = sel_h && !dec_hi;
        assign cmp_wr_hi[h] = sel_h && dec_hi;

        mtimer_cmp_slot #(
            .HALF_W (BUS_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (cmp_wr_lo[h]),
            .wr_hi    (cmp_wr_hi[h]),
            .wdata    (req_wdata),
            .now      (time_q),
            .deadline (cmp_all[h]),
            .irq      (timer_irq[h])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                soft_q[h] <= 1'b0;
            end else if (wr_en && (dec_kind == SEL_SOFT) && (dec_hart == HART_W'(h))) begin
                soft_q[h] <= req_wdata[0];
            end
        end
    end

    assign soft_irq = soft_q;

    // Read data selection
    always_comb begin
        rd_word = '0;
        unique case (dec_kind)
            SEL_SOFT: begin
                for (int h = 0; h < NHART; h++) begin
                    if (dec_hart == HART_W'(h)) begin
                        rd_word = {{(BUS_W-1){1'b0}}, soft_q[h]};
                    end
                end
            end
            SEL_CMP: begin
                for (int h = 0; h < NHART; h++) begin
                    if (dec_hart == HART_W'(h)) begin
                        rd_word = dec_hi ? cmp_all[h][CNT_W-1:BUS_W] : cmp_all[h][BUS_W-1:0];
                    end
                end
            end
            SEL_TIME: rd_word = dec_hi ? time_q[CNT_W-1:BUS_W] : time_q[BUS_W-1:0];
            SEL_NONE: rd_word = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_en ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_en ? ST_RESP : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_word;
        end
    end

    // Outputs
    always_comb begin
        rsp_valid = (state_q == ST_RESP);
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
    parameter int          NHART = 4,
    parameter logic [31:0] BASE  = 32'h0200_0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [31:0]      req_addr,
    input logic             rsp_valid,
    input logic [NHART-1:0] timer_irq,
    input logic [NHART-1:0] soft_irq,
    input logic [63:0]      time_q
);

    localparam logic [31:0] TIME_A = BASE + 32'h0000_BFF8;

    logic time_write;
    assign time_write = req_valid && req_write && (req_addr[31:3] == TIME_A[31:3]);

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !time_write |=> (time_q == $past(time_q) + 64'd1));

    // R8
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R8
    rsp_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    // R4
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(timer_irq) & ~timer_irq)) |-> ($past(req_valid && req_write) || ($past(time_q) == '1)));

    // R6
    soft_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(soft_irq) |-> $past(req_valid && req_write));

    // R7
    outside_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_addr[31:16] != BASE[31:16])) |=> $stable(soft_irq));

endmodule

bind mtimer_top mtimer_chk #(
    .NHART (NHART),
    .BASE  (BASE)
) u_mtimer_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .timer_irq (timer_irq),
    .soft_irq  (soft_irq),
    .time_q    (time_q)
);

// File: tb/tb_mtimer_top.sv
module tb_mtimer_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          NH         = 4;
    localparam logic [31:0] B          = 32'h0200_0000;
    localparam logic [31:0] T_LO       = B + 32'hBFF8;
    localparam logic [31:0] T_HI       = B + 32'hBFFC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [31:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NH-1:0] timer_irq;
    logic [NH-1:0] soft_irq;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    logic [63:0]   mdl_time = '0;
    logic [63:0]   mdl_cmp [NH];
    logic [NH-1:0] mdl_soft = '0;

    mtimer_top #(.NHART(NH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .timer_irq (timer_irq),
        .soft_irq  (soft_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Arithmetic counter model: +1 per cycle, halves replaced on write
    always @(posedge clk) begin
        if (!rst_n) mdl_time <= '0;
        else if (req_valid && req_write && req_addr == T_LO) mdl_time[31:0] <= req_wdata;
        else if (req_valid && req_write && req_addr == T_HI) mdl_time[63:32] <= req_wdata;
        else mdl_time <= mdl_time + 64'd1;
    end

    function automatic logic [31:0] cmp_addr(input int h, input bit hi);
        return B + 32'h4000 + 32'(8 * h) + (hi ? 32'd4 : 32'd0);
    endfunction

    function automatic logic [NH-1:0] exp_irq();
        logic [NH-1:0] v;
        for (int h = 0; h < NH; h++) v[h] = (mdl_time >= mdl_cmp[h]);
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check(rsp_valid == 1'b0, "R8 write gives no response", 64'(rsp_valid), 64'd0);
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R8 read response valid", 64'(rsp_valid), 64'd1);
        d = rsp_rdata;
    endtask

    task automatic read_chk(input logic [31:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        bus_read(a, d);
        check(d == exp, tag, 64'(d), 64'(exp));
    endtask

    task automatic write_cmp(input int h, input bit hi, input logic [31:0] d);
        bus_write(cmp_addr(h, hi), d);
        if (hi) mdl_cmp[h][63:32] = d;
        else    mdl_cmp[h][31:0]  = d;
    endtask

    task automatic idle_check(input int n);
        repeat (n) begin
            @(negedge clk);
            check(timer_irq == exp_irq(), "R4 R5 timer_irq level", 64'(timer_irq), 64'(exp_irq()));
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        for (int h = 0; h < NH; h++) mdl_cmp[h] = '1;

        // R9 reset state
        repeat (3) @(negedge clk);
        check(timer_irq == '0, "R9 timer_irq in reset", 64'(timer_irq), 64'd0);
        check(soft_irq == '0, "R9 soft_irq in reset", 64'(soft_irq), 64'd0);
        check(rsp_valid == 1'b0, "R9 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;

        // R1 counting from zero, checked with literal values
        read_chk(T_LO, 32'd0, "R1 counter first cycle");
        read_chk(T_LO, 32'd1, "R1 counter second cycle");
        read_chk(T_LO, 32'd2, "R1 counter third cycle");
        repeat (5) @(negedge clk);
        read_chk(T_LO, 32'd8, "R1 counter after idle");
        read_chk(T_HI, 32'd0, "R1 counter high word");
        check(timer_irq == '0, "R9 timer_irq after reset", 64'(timer_irq), 64'd0);

        // R3 reset value and readback of every deadline word
        for (int h = 0; h < NH; h++) begin
            read_chk(cmp_addr(h, 0), 32'hFFFF_FFFF, "R3 deadline low reset");
            read_chk(cmp_addr(h, 1), 32'hFFFF_FFFF, "R3 deadline high reset");
        end
        for (int h = 0; h < NH; h++) begin
            write_cmp(h, 1, 32'hF000_0000 + 32'(h));
            write_cmp(h, 0, 32'h1234_5600 + 32'(h * 17));
        end
        for (int h = 0; h < NH; h++) begin
            read_chk(cmp_addr(h, 0), 32'h1234_5600 + 32'(h * 17), "R3 deadline low readback");
            read_chk(cmp_addr(h, 1), 32'hF000_0000 + 32'(h), "R3 deadline high readback");
            write_cmp(h, 1, 32'hFFFF_FFFF);
            write_cmp(h, 0, 32'hFFFF_FFFF);
        end

        // R2 half writes and carry into high word
        bus_write(T_LO, 32'hFFFF_FFFE);
        bus_write(T_HI, 32'h0000_0005);
        read_chk(T_HI, 32'd5, "R2 high after write");
        read_chk(T_HI, 32'd5, "R2 high before carry");
        read_chk(T_HI, 32'd6, "R2 high after carry");
        read_chk(T_LO, 32'd1, "R2 low after carry");
        bus_write(T_LO, 32'h0000_0100);
        repeat (3) @(negedge clk);
        read_chk(T_LO, 32'h0000_0103, "R2 low resumes from written value");

        // R1 wrap of the full 64-bit counter
        bus_write(T_LO, 32'hFFFF_FFFD);
        bus_write(T_HI, 32'hFFFF_FFFF);
        read_chk(T_LO, 32'hFFFF_FFFD, "R1 low before wrap");
        read_chk(T_HI, 32'hFFFF_FFFF, "R1 high before wrap");
        read_chk(T_HI, 32'hFFFF_FFFF, "R1 high at all ones");
        read_chk(T_HI, 32'd0, "R1 high after wrap");
        read_chk(T_LO, 32'd1, "R1 low after wrap");

        // R4 R5 per-hart deadline sweep
        bus_write(T_LO, 32'd1000);
        bus_write(T_HI, 32'd0);
        idle_check(2);
        for (int h = 0; h < NH; h++) begin
            write_cmp(h, 1, 32'd0);
            idle_check(1);
            write_cmp(h, 0, mdl_time[31:0] + 32'd6 + 32'(h));
            idle_check(12);
            check(timer_irq[h] == 1'b1, "R4 irq raised after deadline", 64'(timer_irq[h]), 64'd1);
            write_cmp(h, 1, 32'd1);
            check(timer_irq[h] == 1'b0, "R4 irq cleared next cycle", 64'(timer_irq[h]), 64'd0);
            idle_check(2);
        end
        // R4 equality boundary: deadline equal to counter value
        write_cmp(2, 1, 32'd0);
        write_cmp(2, 0, mdl_time[31:0] + 32'd2);
        idle_check(3);
        write_cmp(2, 1, 32'd1);
        idle_check(1);

        // R6 software flags
        for (int h = 0; h < NH; h++) begin
            bus_write(B + 32'(4 * h), 32'h0000_0001);
            mdl_soft[h] = 1'b1;
            check(soft_irq == mdl_soft, "R6 soft set", 64'(soft_irq), 64'(mdl_soft));
        end
        for (int h = 0; h < NH; h++) read_chk(B + 32'(4 * h), 32'd1, "R6 soft readback");
        bus_write(B + 32'd4, 32'hFFFF_FFFE);
        mdl_soft[1] = 1'b0;
        check(soft_irq == mdl_soft, "R6 soft cleared by bit0 only", 64'(soft_irq), 64'(mdl_soft));
        read_chk(B + 32'd4, 32'd0, "R6 soft cleared readback");
        bus_write(B, 32'd0);
        mdl_soft[0] = 1'b0;
        check(soft_irq == mdl_soft, "R6 soft clear hart0", 64'(soft_irq), 64'(mdl_soft));

        // R7 unmapped offsets and addresses outside the window
        bus_write(B + 32'h4000 + 32'(8 * NH), 32'h1234_5678);
        read_chk(B + 32'h4000 + 32'(8 * NH), 32'd0, "R7 past last deadline");
        read_chk(cmp_addr(NH - 1, 1), 32'd1, "R7 last deadline untouched");
        read_chk(B + 32'h1000, 32'd0, "R7 hole in window");
        read_chk(B + 32'hBFF0, 32'd0, "R7 below counter");
        bus_write(B + 32'(4 * NH), 32'd1);
        check(soft_irq == mdl_soft, "R7 soft beyond harts ignored", 64'(soft_irq), 64'(mdl_soft));
        read_chk(B + 32'(4 * NH), 32'd0, "R7 soft beyond harts reads zero");
        bus_write(32'h0300_0000, 32'd1);
        check(soft_irq == mdl_soft, "R7 outside window write ignored", 64'(soft_irq), 64'(mdl_soft));
        bus_write(32'h0300_4000, 32'd0);
        read_chk(cmp_addr(0, 1), 32'd1, "R7 deadline untouched by outside write");
        read_chk(32'h0300_4004, 32'd0, "R7 outside window reads zero");
        idle_check(2);

        // R8 back-to-back reads then idle
        bus_read(B + 32'h8, d);
        bus_read(B + 32'h8, d);
        check(d == 32'd1, "R8 back-to-back read data", 64'(d), 64'd1);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8 no response when idle", 64'(rsp_valid), 64'd0);

        finish_run();
    end

endmodule